// File: doc/BRIEF.md
# Floating-Point Exception Trap Generator

This block sits at the end of a floating-point pipeline. When an operation retires, it receives the five IEEE exception flags that the operation raised. It also receives two qualifier bits taken from the instruction and the number of the destination register. From these it decides whether an arithmetic trap must be taken. On a trap it produces a one-cycle trap pulse, a summary word that tells the handler which exceptions caused the trap, and a record of the destination registers that have trapped.

Two policies are supported, and each operation selects one through its software-completion qualifier:

- **Without software completion**, every flag that survives the inexact filter traps.
- **With software completion**, the flags are first recorded in a sticky status register. Only the flags that are not masked by a writable enable-mask register lead to a trap.

In both policies the inexact flag is dropped unless the operation enables inexact detection.

Top module: `ftrap_gen`

## Requirements
- R1: After reset is asserted, trap_o is 0, and trap_sum_o, trap_regs_o, sticky_o and en_mask_o are all zero.
- R2: The op_flags_i bits are encoded as follows: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. When op_qual_i[0] (inexact enable, instruction bit 9) is 0, the inexact flag is discarded before any other step. It then neither traps nor reaches sticky_o.
- R3: When op_qual_i[1] (software completion, instruction bit 10) is 0 and the filtered flags are nonzero, trap_o is 1 in the cycle after op_valid_i. This holds whatever value en_mask_o has, and sticky_o is left unchanged.
- R4: When op_qual_i[1] is 1, the filtered flags are ORed into sticky_o at the next clock edge. A trap follows only if (filtered flags AND NOT en_mask_o) is nonzero.
- R5: When trap_o is 1, trap_sum_o holds the flags that caused the trap, in this layout: bit 1 invalid, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow, bit 5 inexact. Bits 0 and 6 are 0. When trap_o is 0, trap_sum_o is zero.
- R6: Every trap sets bit (op_dest_i + 32) of trap_regs_o. Bits that are already set stay set until reset.
- R7: An operation with all flags zero, or a cycle with op_valid_i low, leaves trap_o at 0 and leaves sticky_o and trap_regs_o unchanged.
- R8: A cycle with en_we_i high loads en_wdata_i into en_mask_o at the next clock edge. An operation in that same cycle is filtered with the old mask.
- R9: trap_o is a one-cycle pulse per trapping operation. It returns to 0 in the cycle after a non-trapping or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operation retires this cycle |
| op_flags_i | input | 5 | IEEE exception flags of the operation |
| op_qual_i | input | 2 | [0] inexact enable, [1] software completion |
| op_dest_i | input | 5 | Destination register number |
| en_we_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | 5 | New enable-mask value, same bit order as the flags |
| trap_o | output | 1 | Arithmetic trap pulse |
| trap_sum_o | output | 7 | Exception summary word for the trap |
| trap_regs_o | output | 64 | Accumulated destination-register trap mask |
| sticky_o | output | 5 | Sticky exception status |
| en_mask_o | output | 5 | Current enable mask |

## Verification
The bench builds the block with its default parameters: a 5-bit destination number, a 64-bit register trap mask, and an offset of 32.

With these values, destination 0 and destination 31 reach the lowest and highest decoded bits (32 and 63). The bench drives both to check the edges of the decode. It also walks each flag on its own through the summary layout. The software-completion path is exercised with partial masks and with a mask write that lands in the same cycle as an operation.

// File: rtl/ftrap_pkg.sv
package ftrap_pkg;
  localparam int FLAG_W = 5;
  localparam int SUM_W  = 7;

  typedef logic [FLAG_W-1:0] flag_t;
  typedef logic [SUM_W-1:0]  sum_t;

  typedef enum int {
    FL_INV = 0,
    FL_DZE = 1,
    FL_OVF = 2,
    FL_UNF = 3,
    FL_INX = 4
  } flag_idx_e;

  // qualifier field positions
  localparam int Q_INX = 0;
  localparam int Q_SWC = 1;

  // summary bit of flag i is i+1
  function automatic sum_t to_summary(flag_t f);
    sum_t s;
    s = '0;
    for (int i = 0; i < FLAG_W; i++) s[i+1] = f[i];
    return s;
  endfunction
endpackage

// File: rtl/ftrap_filter.sv
module ftrap_filter
  import ftrap_pkg::*;
(
  input  logic       valid_i,
  input  flag_t      flags_i,
  input  logic [1:0] qual_i,
  input  flag_t      en_mask_i,
  output flag_t      sticky_set_o,
  output flag_t      raise_o,
  output logic       fire_o
);
  flag_t keep;
  flag_t kept;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_keep
    if (g == FL_INX) begin : g_inx
      assign keep[g] = qual_i[Q_INX];
    end else begin : g_other
      assign keep[g] = 1'b1;
    end
  end

  assign kept = valid_i ? (flags_i & keep) : '0;

  always_comb begin
    if (qual_i[Q_SWC]) begin
      sticky_set_o = kept;
      raise_o      = kept & ~en_mask_i;
    end else begin
      sticky_set_o = '0;
      raise_o      = kept;
    end
  end

  assign fire_o = |raise_o;
endmodule

// File: rtl/ftrap_state.sv
module ftrap_state
  import ftrap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  flag_t sticky_set_i,
  input  logic  we_i,
  input  flag_t wdata_i,
  output flag_t sticky_o,
  output flag_t en_mask_o
);
  flag_t sticky_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      sticky_q <= sticky_q | sticky_set_i;
      if (we_i) mask_q <= wdata_i;
    end
  end

  assign sticky_o  = sticky_q;
  assign en_mask_o = mask_q;
endmodule

// File: rtl/ftrap_emit.sv
module ftrap_emit
  import ftrap_pkg::*;
#(
  parameter int DEST_W  = 5,
  parameter int REGS_W  = 64,
  parameter int REG_OFS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  flag_t             raise_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic              trap_o,
  output sum_t              sum_o,
  output logic [REGS_W-1:0] regs_o
);
  localparam int NREG = 2 ** DEST_W;

  logic [REGS_W-1:0] hit;
  logic              trap_q;
  sum_t              sum_q;
  logic [REGS_W-1:0] regs_q;

  for (genvar g = 0; g < REGS_W; g++) begin : g_dec
    if (g >= REG_OFS && g < REG_OFS + NREG) begin : g_live
      assign hit[g] = fire_i && (dest_i == DEST_W'(g - REG_OFS));
    end else begin : g_dead
      assign hit[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      sum_q  <= '0;
      regs_q <= '0;
    end else begin
      trap_q <= fire_i;
      sum_q  <= fire_i ? to_summary(raise_i) : '0;
      regs_q <= regs_q | hit;
    end
  end

  assign trap_o = trap_q;
  assign sum_o  = sum_q;
  assign regs_o = regs_q;
endmodule

// File: rtl/ftrap_gen.sv
module ftrap_gen
  import ftrap_pkg::*;
#(
  parameter int DEST_W  = 5,
  parameter int REGS_W  = 64,
  parameter int REG_OFS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [4:0]        op_flags_i,
  input  logic [1:0]        op_qual_i,
  input  logic [DEST_W-1:0] op_dest_i,
  input  logic              en_we_i,
  input  logic [4:0]        en_wdata_i,
  output logic              trap_o,
  output logic [6:0]        trap_sum_o,
  output logic [REGS_W-1:0] trap_regs_o,
  output logic [4:0]        sticky_o,
  output logic [4:0]        en_mask_o
);
  flag_t sticky_set, raise, mask;
  logic  fire;

  ftrap_filter u_filter (
    .valid_i      (op_valid_i),
    .flags_i      (op_flags_i),
    .qual_i       (op_qual_i),
    .en_mask_i    (mask),
    .sticky_set_o (sticky_set),
    .raise_o      (raise),
    .fire_o       (fire)
  );

  ftrap_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sticky_set_i (sticky_set),
    .we_i         (en_we_i),
    .wdata_i      (en_wdata_i),
    .sticky_o     (sticky_o),
    .en_mask_o    (mask)
  );

  ftrap_emit #(
    .DEST_W  (DEST_W),
    .REGS_W  (REGS_W),
    .REG_OFS (REG_OFS)
  ) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .raise_i (raise),
    .dest_i  (op_dest_i),
    .trap_o  (trap_o),
    .sum_o   (trap_sum_o),
    .regs_o  (trap_regs_o)
  );

  assign en_mask_o = mask;
endmodule

// File: rtl/ftrap_chk.sv
module ftrap_chk #(
  parameter int DEST_W = 5,
  parameter int REGS_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [4:0]        op_flags_i,
  input logic [1:0]        op_qual_i,
  input logic [DEST_W-1:0] op_dest_i,
  input logic              en_we_i,
  input logic [4:0]        en_wdata_i,
  input logic              trap_o,
  input logic [6:0]        trap_sum_o,
  input logic [REGS_W-1:0] trap_regs_o,
  input logic [4:0]        sticky_o,
  input logic [4:0]        en_mask_o
);
  a_r9_pulse_needs_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !trap_o);

  a_r2_no_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_qual_i[0]) |=> !trap_sum_o[5]);

  a_r3_plain_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_qual_i[1] && (op_flags_i[3:0] != 4'd0)) |=> trap_o);

  a_r4_sticky_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

  a_r6_regs_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((trap_regs_o & $past(trap_regs_o)) == $past(trap_regs_o)));

  a_r5_sum_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (trap_sum_o == 7'd0));

  a_r5_sum_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_sum_o[5:1] != 5'd0 && !trap_sum_o[0] && !trap_sum_o[6]));

  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> ($stable(sticky_o) && $stable(trap_regs_o)));

  a_r8_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_mask_o == $past(en_wdata_i)));
endmodule

bind ftrap_gen ftrap_chk #(.DEST_W(DEST_W), .REGS_W(REGS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_flags_i  (op_flags_i),
  .op_qual_i   (op_qual_i),
  .op_dest_i   (op_dest_i),
  .en_we_i     (en_we_i),
  .en_wdata_i  (en_wdata_i),
  .trap_o      (trap_o),
  .trap_sum_o  (trap_sum_o),
  .trap_regs_o (trap_regs_o),
  .sticky_o    (sticky_o),
  .en_mask_o   (en_mask_o)
);

// File: tb/sim_ftrap_gen.sv
`timescale 1ns/1ps
module sim_ftrap_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [4:0]  flags;
  logic [1:0]  qual;
  logic [4:0]  dest;
  logic        we;
  logic [4:0]  wd;
  logic        trap;
  logic [6:0]  sum;
  logic [63:0] regs;
  logic [4:0]  sticky;
  logic [4:0]  mask;

  always #2 clk = ~clk;

  ftrap_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_flags_i(flags),
    .op_qual_i(qual), .op_dest_i(dest), .en_we_i(we), .en_wdata_i(wd),
    .trap_o(trap), .trap_sum_o(sum), .trap_regs_o(regs),
    .sticky_o(sticky), .en_mask_o(mask)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic        e_trap;
  logic [6:0]  e_sum;
  logic [63:0] e_regs;
  logic [4:0]  e_sticky, e_mask;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp(tag, "trap", 64'(trap), 64'(e_trap));
    cmp(tag, "sum", 64'(sum), 64'(e_sum));
    cmp(tag, "regs", regs, e_regs);
    cmp(tag, "sticky", 64'(sticky), 64'(e_sticky));
    cmp(tag, "mask", 64'(mask), 64'(e_mask));
  endtask

  // reference model: predicts outputs after the next rising edge
  task automatic step(input logic v, input logic [4:0] f, input logic [1:0] q,
                      input logic [4:0] d, input logic w, input logic [4:0] wv,
                      input string tag);
    logic [4:0] kept, hit;
    int idx;
    valid = v; flags = f; qual = q; dest = d; we = w; wd = wv;
    kept = v ? f : 5'd0;
    if (!q[0]) kept[4] = 1'b0;
    hit = 5'd0;
    if (q[1]) begin
      e_sticky = e_sticky | kept;
      hit = kept & ~e_mask;
    end else begin
      hit = kept;
    end
    e_trap = (hit != 0);
    e_sum  = 7'd0;
    if (e_trap) begin
      for (int i = 0; i < 5; i++) e_sum[i+1] = hit[i];
      idx = int'(d) + 32;
      e_regs[idx] = 1'b1;
    end
    if (w) e_mask = wv;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 5'h1f, 2'b11, 5'd3, 1'b0, 5'd0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    valid = 0; flags = 0; qual = 0; dest = 0; we = 0; wd = 0;
    e_trap = 0; e_sum = 0; e_regs = 0; e_sticky = 0; e_mask = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R7: valid low with flags present, then zero flags with valid
    idle("R7");
    step(1'b1, 5'd0, 2'b11, 5'd4, 1'b0, 5'd0, "R7");

    // R3: plain path traps even though the mask covers everything
    step(1'b0, 5'd0, 2'b00, 5'd0, 1'b1, 5'h1f, "R8");
    step(1'b1, 5'b00001, 2'b00, 5'd0, 1'b0, 5'd0, "R3");
    idle("R9");

    // R2: inexact only, I clear, both paths -> nothing
    step(1'b1, 5'b10000, 2'b00, 5'd7, 1'b0, 5'd0, "R2");
    step(1'b1, 5'b10000, 2'b10, 5'd7, 1'b0, 5'd0, "R2");
    // R2: inexact with I set traps on the plain path
    step(1'b1, 5'b10000, 2'b01, 5'd31, 1'b0, 5'd0, "R2");

    // R5: each flag alone on the plain path, back-to-back (R9)
    for (int i = 0; i < 5; i++) step(1'b1, 5'(1 << i), 2'b01, 5'(i + 8), 1'b0, 5'd0, "R5");
    idle("R9");

    // R4: software completion, mask all -> sticky only
    step(1'b1, 5'b00110, 2'b11, 5'd12, 1'b0, 5'd0, "R4");
    // R8: clear mask bits 0 and 3 while an op runs with the old mask
    step(1'b1, 5'b01001, 2'b11, 5'd13, 1'b1, 5'b10110, "R8");
    // R4: now the same flags trap, masked ones do not
    step(1'b1, 5'b01111, 2'b11, 5'd14, 1'b0, 5'd0, "R4");
    step(1'b1, 5'b10110, 2'b11, 5'd15, 1'b0, 5'd0, "R4");
    // R2 on the software path: inexact unmasked but I clear
    step(1'b0, 5'd0, 2'b00, 5'd0, 1'b1, 5'd0, "R8");
    step(1'b1, 5'b10000, 2'b10, 5'd16, 1'b0, 5'd0, "R2");
    step(1'b1, 5'b10000, 2'b11, 5'd17, 1'b0, 5'd0, "R4");

    // R6: edge destinations and a repeated hit
    step(1'b1, 5'b00100, 2'b00, 5'd0, 1'b0, 5'd0, "R6");
    step(1'b1, 5'b00100, 2'b00, 5'd31, 1'b0, 5'd0, "R6");
    step(1'b1, 5'b00010, 2'b00, 5'd0, 1'b0, 5'd0, "R6");
    idle("R9");

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    e_trap = 0; e_sum = 0; e_regs = 0; e_sticky = 0; e_mask = 0;
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    idle("R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule